// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Fetch Steering

This block is the front-end control of a five-stage in-order pipeline. It resolves conditional branches in the decode stage and decides where the fetch program counter goes next. A branch tests one register against zero, using either "equal to zero" or "not equal to zero". A dedicated adder in decode builds the taken target, so a branch costs at most one cycle.

A runtime policy select chooses one of three ways to handle the instruction fetched behind a branch:

- **Stall**: fetch holds while the branch resolves, and every branch costs one penalty cycle.
- **Predict-not-taken**: the fetched instruction is squashed and fetch redirects only when the branch is taken.
- **Delayed**: the single instruction after the branch always executes, and the redirect takes effect after it.

A global pipeline hold from outside freezes the PC and suppresses all redirect and squash activity. A branch that is still presented when the hold releases is then acted upon. A saturating counter reports the total number of penalty cycles.

The control is a two-state machine:

- **ST_RUN**: normal operation.
- **ST_SLOT**: a delay-slot instruction occupies decode.

It has three transitions:

- **RUN→SLOT**: taken on a branch in delayed policy with no hold.
- **SLOT→RUN**: taken on any cycle without hold.
- **Self-loop**: the machine stays in its current state on any cycle with hold asserted, or in ST_RUN without a delayed branch.

Top module: `branch_front_ctl`

## Requirements
- R1: After reset, `fetch_pc` equals the parameter RESET_PC, `penalty_cnt` is 0, and with no branch presented `squash_if` and `stall_req` are 0.
- R2: In a cycle without hold and without an accepted branch, `fetch_pc` advances by 4 at the next clock edge. A branch kind presented with `id_valid` low is not a branch.
- R3: Branch kind encoding on `id_br_kind`:
  - 2'b01 is taken when `id_rs_val` is zero.
  - 2'b10 is taken when `id_rs_val` is non-zero.
  - 2'b00 and 2'b11 are not branches.
- R4: The taken target is `id_pc` + 4 + (sign-extended `id_offset` shifted left by two), which also holds for negative offsets.
- R5: In predict-not-taken policy, a taken branch raises `squash_if` in the same cycle. `fetch_pc` becomes the target at the next edge, and `penalty_cnt` increases by 1.
- R6: In predict-not-taken policy, an untaken branch raises neither `squash_if` nor `stall_req`, costs no penalty cycle, and `fetch_pc` advances by 4.
- R7: In stall policy, every branch raises `stall_req` and `squash_if` in the same cycle, and `penalty_cnt` increases by 1. At the next edge `fetch_pc` becomes the target if taken; if untaken it keeps its value, so the same address is fetched again.
- R8: In delayed policy, a branch raises no squash and no stall, and costs no penalty. At the next edge `fetch_pc` becomes the target if taken, or PC+4 if untaken.
- R9: The instruction in decode in the cycle after a delayed-policy branch is the delay slot. A branch there is ignored, and `fetch_pc` advances by 4.
- R10: While `hold_in` is 1:
  - `fetch_pc` and `penalty_cnt` keep their values.
  - `squash_if` and `stall_req` are 0.
  - A branch presented when the hold releases is then acted upon.
  - A delay slot pending across the hold is still consumed as a slot.
- R11: `penalty_cnt` (PEN_W bits) saturates at 2^PEN_W-1 and does not wrap.
- R12: Policy encoding on `policy_sel`:
  - 2'b00 is stall.
  - 2'b01 is predict-not-taken.
  - 2'b10 is delayed.
  - 2'b11 behaves as stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Branch policy select |
| hold_in | input | 1 | Global pipeline hold |
| id_valid | input | 1 | Decode-stage instruction is valid |
| id_br_kind | input | 2 | Decoded branch kind |
| id_rs_val | input | XLEN | Register operand read in decode |
| id_offset | input | OFF_W | Branch word offset |
| id_pc | input | XLEN | PC of the decode-stage instruction |
| fetch_pc | output | XLEN | Address being fetched this cycle |
| squash_if | output | 1 | Clears the valid bit of the fetch-stage instruction |
| stall_req | output | 1 | Fetch hold request while a branch resolves |
| penalty_cnt | output | PEN_W | Saturating count of penalty cycles |

## Verification
The block has two kinds of result, and they fall due at different times:

- **Same-cycle results**: `squash_if` and `stall_req` are combinational. They are due in the same cycle in which the branch is presented.
- **Registered results**: `fetch_pc` and `penalty_cnt` are registered. They are due one rising edge later.

The driver applies each stimulus at a falling edge and queues the expected values for that cycle. The monitor checks the same-cycle signals 1 ns after that falling edge. It then checks the registered signals 1 ns after the following rising edge, before the next stimulus is applied.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [1:0] {
        POL_STALL     = 2'b00,
        POL_PNT       = 2'b01,
        POL_DELAY     = 2'b10,
        POL_STALL_ALT = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        BK_NONE     = 2'b00,
        BK_EQZ      = 2'b01,
        BK_NEZ      = 2'b10,
        BK_NONE_ALT = 2'b11
    } brkind_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SLOT = 1'b1
    } fsm_e;

endpackage

// File: rtl/bfc_resolve.sv
module bfc_resolve
    import bfc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic             id_valid,
    input  logic [1:0]       br_kind,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  br_pc,
    input  logic [OFF_W-1:0] offset,
    output logic             is_branch,
    output logic             cond_true,
    output logic [XLEN-1:0]  target
);
    localparam int SH_W = OFF_W + 2;
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    logic [XLEN-1:0] disp;
    logic            rs_zero;
    brkind_e         kind;

    // displacement: word offset, sign-extended, scaled to bytes
    generate
        if (SH_W < XLEN) begin : g_ext
            assign disp = {{(XLEN-SH_W){offset[OFF_W-1]}}, offset, 2'b00};
        end else begin : g_trunc
            logic [SH_W-1:0] wide;
            assign wide = {offset, 2'b00};
            assign disp = wide[XLEN-1:0];
        end
    endgenerate

    assign rs_zero = (rs_val == '0);
    assign kind    = brkind_e'(br_kind);

    always_comb begin
        is_branch = 1'b0;
        cond_true = 1'b0;
        unique case (kind)
            BK_EQZ: begin
                is_branch = id_valid;
                cond_true = rs_zero;
            end
            BK_NEZ: begin
                is_branch = id_valid;
                cond_true = !rs_zero;
            end
            BK_NONE, BK_NONE_ALT: begin
                is_branch = 1'b0;
                cond_true = 1'b0;
            end
        endcase
    end

    // dedicated decode-stage target adder
    assign target = br_pc + WORD + disp;

endmodule

// File: rtl/bfc_fsm.sv
module bfc_fsm
    import bfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [1:0] policy,
    input  logic       is_branch,
    input  logic       cond_true,
    output logic       take_target,
    output logic       keep_pc,
    output logic       squash,
    output logic       stall_req,
    output logic       in_slot
);
    fsm_e    state, state_nx;
    policy_e pol;

    assign pol     = policy_e'(policy);
    assign in_slot = (state == ST_SLOT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx    = state;
        take_target = 1'b0;
        keep_pc     = 1'b0;
        squash      = 1'b0;
        stall_req   = 1'b0;
        if (!hold) begin
            unique case (state)
                ST_SLOT: begin
                    // delay-slot instruction leaves decode; any branch in it is ignored
                    state_nx = ST_RUN;
                end
                ST_RUN: begin
                    if (is_branch) begin
                        unique case (pol)
                            POL_STALL, POL_STALL_ALT: begin
                                squash      = 1'b1;
                                stall_req   = 1'b1;
                                take_target = cond_true;
                                keep_pc     = !cond_true;
                            end
                            POL_PNT: begin
                                squash      = cond_true;
                                take_target = cond_true;
                            end
                            POL_DELAY: begin
                                take_target = cond_true;
                                state_nx    = ST_SLOT;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assert_stall_squashes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> squash);

    assert_slot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT) |-> (!squash && !take_target && !stall_req));

    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!squash && !stall_req && !take_target && !keep_pc));

    assert_slot_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLOT) && !hold) |=> (state == ST_RUN));

    assert_hold_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(state));

endmodule

// File: rtl/bfc_penalty.sv
module bfc_penalty #(
    parameter int PEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [PEN_W-1:0] count
);
    localparam logic [PEN_W-1:0] MAXV = {PEN_W{1'b1}};
    localparam logic [PEN_W-1:0] ONE  = PEN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (bump && (count != MAXV)) count <= count + ONE;
    end

    assert_pen_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV) |=> (count == MAXV));

    assert_pen_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && (count != MAXV)) |=> (count == $past(count) + ONE));

endmodule

// File: rtl/branch_front_ctl.sv
module branch_front_ctl
    import bfc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              OFF_W    = 16,
    parameter int              PEN_W    = 8,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_sel,
    input  logic             hold_in,
    input  logic             id_valid,
    input  logic [1:0]       id_br_kind,
    input  logic [XLEN-1:0]  id_rs_val,
    input  logic [OFF_W-1:0] id_offset,
    input  logic [XLEN-1:0]  id_pc,
    output logic [XLEN-1:0]  fetch_pc,
    output logic             squash_if,
    output logic             stall_req,
    output logic [PEN_W-1:0] penalty_cnt
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    logic            is_branch, cond_true, take_target, keep_pc, in_slot;
    logic [XLEN-1:0] target, pc_nx;

    bfc_resolve #(.XLEN(XLEN), .OFF_W(OFF_W)) u_resolve (
        .id_valid (id_valid),
        .br_kind  (id_br_kind),
        .rs_val   (id_rs_val),
        .br_pc    (id_pc),
        .offset   (id_offset),
        .is_branch(is_branch),
        .cond_true(cond_true),
        .target   (target)
    );

    bfc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold_in),
        .policy     (policy_sel),
        .is_branch  (is_branch),
        .cond_true  (cond_true),
        .take_target(take_target),
        .keep_pc    (keep_pc),
        .squash     (squash_if),
        .stall_req  (stall_req),
        .in_slot    (in_slot)
    );

    bfc_penalty #(.PEN_W(PEN_W)) u_penalty (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (squash_if),
        .count(penalty_cnt)
    );

    always_comb begin
        if (hold_in)          pc_nx = fetch_pc;
        else if (take_target) pc_nx = target;
        else if (keep_pc)     pc_nx = fetch_pc;
        else                  pc_nx = fetch_pc + WORD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fetch_pc <= RESET_PC;
        else        fetch_pc <= pc_nx;
    end

    assert_hold_freezes_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_in |=> $stable(fetch_pc));

    assert_hold_freezes_pen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_in |=> $stable(penalty_cnt));

    assert_no_squash_no_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_if |=> $stable(penalty_cnt));

    assert_slot_sequential_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && !hold_in) |=> (fetch_pc == $past(fetch_pc) + WORD));

endmodule

// File: tb/tb_branch_front_ctl.sv
`timescale 1ns/100ps
module tb_branch_front_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  policy_sel = 2'b00;
    logic        hold_in = 1'b0;
    logic        id_valid = 1'b0;
    logic [1:0]  id_br_kind = 2'b00;
    logic [31:0] id_rs_val = '0;
    logic [15:0] id_offset = '0;
    logic [31:0] id_pc = '0;
    logic [31:0] fetch_pc;
    logic        squash_if, stall_req;
    logic [7:0]  penalty_cnt;

    always #2.5 clk = ~clk;

    branch_front_ctl dut (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .hold_in(hold_in),
        .id_valid(id_valid), .id_br_kind(id_br_kind), .id_rs_val(id_rs_val),
        .id_offset(id_offset), .id_pc(id_pc), .fetch_pc(fetch_pc),
        .squash_if(squash_if), .stall_req(stall_req), .penalty_cnt(penalty_cnt)
    );

    typedef struct {
        logic        sq;
        logic        st;
        logic [31:0] pc;
        logic [7:0]  pen;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pc;
    logic [7:0]  m_pen;
    logic        m_slot;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: one call per cycle, pushes the expected outcome
    task automatic step(input logic [1:0] pol, input logic v, input logic [1:0] k,
                        input logic [31:0] rs, input logic [15:0] off, input logic hld,
                        input string tag);
        exp_t e;
        logic [31:0] ipc, tgt, nxt;
        logic br, tk, sq, st;
        @(negedge clk);
        ipc = m_pc - 32'd4;
        policy_sel = pol; id_valid = v; id_br_kind = k; id_rs_val = rs;
        id_offset = off; id_pc = ipc; hold_in = hld;
        br  = v && (k == 2'b01 || k == 2'b10) && !m_slot;
        tk  = (k == 2'b01) ? (rs == 0) : (rs != 0);
        tgt = ipc + 32'd4 + {{14{off[15]}}, off, 2'b00};
        sq = 1'b0; st = 1'b0; nxt = m_pc + 32'd4;
        if (hld) begin
            nxt = m_pc;
        end else if (m_slot) begin
            m_slot = 1'b0;
        end else if (br) begin
            case (pol)
                2'b01: if (tk) begin sq = 1'b1; nxt = tgt; end
                2'b10: begin nxt = tk ? tgt : m_pc + 32'd4; m_slot = 1'b1; end
                default: begin sq = 1'b1; st = 1'b1; nxt = tk ? tgt : m_pc; end
            endcase
        end
        if (sq && m_pen != 8'hFF) m_pen = m_pen + 8'd1;
        m_pc = nxt;
        e.sq = sq; e.st = st; e.pc = nxt; e.pen = m_pen; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(2'b01, 1'b0, 2'b00, 32'd0, 16'd0, 1'b0, tag);
    endtask

    // monitor: combinational results in the stimulus cycle, registered ones after the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q[0];
                chk(e.tag, "squash_if", {31'd0, squash_if}, {31'd0, e.sq});
                chk(e.tag, "stall_req", {31'd0, stall_req}, {31'd0, e.st});
                @(posedge clk);
                #1;
                chk(e.tag, "fetch_pc", fetch_pc, e.pc);
                chk(e.tag, "penalty_cnt", {24'd0, penalty_cnt}, {24'd0, e.pen});
                void'(q.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_pc = 32'd0; m_pen = 8'd0; m_slot = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "fetch_pc", fetch_pc, 32'd0);
        chk("R1", "penalty_cnt", {24'd0, penalty_cnt}, 32'd0);
        chk("R1", "squash_if", {31'd0, squash_if}, 32'd0);
        chk("R1", "stall_req", {31'd0, stall_req}, 32'd0);
        @(posedge clk);
        m_pc = 32'd4;

        // R2: sequential advance, invalid branch ignored, R3 kind 11 not a branch
        idle("R2");
        idle("R2");
        step(2'b01, 1'b0, 2'b01, 32'd0, 16'd10, 1'b0, "R2");
        step(2'b00, 1'b1, 2'b11, 32'd0, 16'd10, 1'b0, "R3");
        step(2'b00, 1'b1, 2'b00, 32'd0, 16'd10, 1'b0, "R3");

        // predict-not-taken: R5, R4, R6, R3
        step(2'b01, 1'b1, 2'b01, 32'd0, 16'd8, 1'b0, "R5");
        idle("R5");
        step(2'b01, 1'b1, 2'b01, 32'd5, 16'd8, 1'b0, "R6");
        step(2'b01, 1'b1, 2'b10, 32'd7, 16'hFFFD, 1'b0, "R4");
        idle("R4");
        step(2'b01, 1'b1, 2'b10, 32'd0, 16'd3, 1'b0, "R6");

        // stall policy R7, reserved encoding R12
        step(2'b00, 1'b1, 2'b01, 32'd0, 16'd20, 1'b0, "R7");
        idle("R7");
        step(2'b00, 1'b1, 2'b10, 32'd0, 16'd20, 1'b0, "R7");
        step(2'b11, 1'b1, 2'b10, 32'd9, 16'hFFF0, 1'b0, "R12");
        step(2'b11, 1'b1, 2'b01, 32'd9, 16'd4, 1'b0, "R12");

        // delayed policy R8, slot branch ignored R9
        step(2'b10, 1'b1, 2'b10, 32'd1, 16'd12, 1'b0, "R8");
        step(2'b10, 1'b1, 2'b01, 32'd0, 16'd40, 1'b0, "R9");
        step(2'b10, 1'b1, 2'b01, 32'd3, 16'd12, 1'b0, "R8");
        idle("R8");

        // hold R10
        step(2'b01, 1'b1, 2'b01, 32'd0, 16'd6, 1'b1, "R10");
        step(2'b01, 1'b1, 2'b01, 32'd0, 16'd6, 1'b1, "R10");
        step(2'b01, 1'b1, 2'b01, 32'd0, 16'd6, 1'b0, "R10");
        step(2'b10, 1'b1, 2'b01, 32'd0, 16'd2, 1'b0, "R10");
        step(2'b10, 1'b1, 2'b10, 32'd1, 16'd30, 1'b1, "R10");
        step(2'b00, 1'b1, 2'b10, 32'd1, 16'd30, 1'b0, "R9");
        idle("R10");

        // saturation R11
        for (int i = 0; i < 262; i++)
            step(2'b01, 1'b1, 2'b01, 32'd0, 16'd1, 1'b0, "R11");
        step(2'b00, 1'b1, 2'b10, 32'd2, 16'd1, 1'b0, "R11");
        idle("R11");

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule